// File: doc/BRIEF.md
# I2C Register Access Target

This block is an I2C target that lets an external bus master reach a bank of registers 8, 16 or 32 bits wide. The open-drain SCL and SDA lines pass through a synchronizer and a glitch filter. The block then finds START, repeated START and STOP conditions and shifts bytes in and out. The target answers to the fixed 7-bit address 0111000b. Address byte 0x70 selects a write and 0x71 selects a read.

A write transaction first loads a 16-bit register pointer, sent high byte first. A read uses two phases. The master sets the pointer with a write, then issues a repeated START and the read address byte. The block asks the register file for the pointed-to register and learns its width. It then returns 1, 2 or 4 bytes, most significant byte first. The master ends the read with a NACK. Data bytes that follow the pointer in a write are gathered and handed to the register file as one write when the transaction ends.

The register-file port is a plain parallel interface with a fixed latency and no back-pressure. After a one-cycle `rd_req`, the file must present `rd_data` and `rd_size` on the next clock. When `wr_strobe` pulses, the file must take `wr_addr`, `wr_data` and `wr_bytes` in that same cycle. The block has no ready input and never waits for the register file.

Top module: `i2c_reg_target`

## Requirements
- R1: An address byte whose upper seven bits equal 0111000b is acknowledged: SDA is held low through the ninth clock. Any other address is not acknowledged, and SDA stays released until the next START.
- R2: After write address 0x70, the next two bytes set the 16-bit pointer. The first byte holds bits 15..8 and the second holds bits 7..0. The target acknowledges each of the two bytes.
- R3: When the eighth bit of read address 0x71 is sampled, `rd_req` pulses for exactly one cycle with `rd_addr` equal to the pointer. `rd_data`/`rd_size` are taken on the following clock. The pointer keeps its value across transactions.
- R4: The read returns the low-order bytes of `rd_data`, most significant bit first and most significant byte first. `rd_size` sets the byte count: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes.
- R5: A master ACK after a non-final byte makes the target send the next byte. A master NACK returns it to idle with SDA released. A master ACK after the final byte also returns it to idle, so any further clocks read all ones.
- R6: Data bytes after the pointer are acknowledged and gathered, up to four. A fifth byte is not acknowledged. On the STOP or START that ends the transaction, if at least one data byte arrived, `wr_strobe` pulses for one cycle. With it come `wr_addr` equal to the pointer and `wr_bytes` equal to the byte count. `wr_data` holds the bytes right-aligned, with the first byte most significant. A transaction with no data byte produces no strobe.
- R7: A STOP at any point returns the target to idle with SDA released. A START at any point begins a new address byte, and a partly received byte is discarded.
- R8: `sda_oe` changes only while the filtered SCL is low, and received bits are sampled on the rising edge of SCL.
- R9: Reset leaves `sda_oe`, `rd_req` and `wr_strobe` low and the pointer at 0.
- R10: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_addr | output | 16 | Register address for a read |
| rd_req | output | 1 | One-cycle read request |
| rd_data | input | 32 | Register value, valid the cycle after `rd_req` |
| rd_size | input | 2 | Register width code, valid with `rd_data` |
| wr_addr | output | 16 | Register address for a write |
| wr_data | output | 32 | Gathered write bytes, right-aligned |
| wr_bytes | output | 3 | Number of valid bytes in `wr_data` (1..4) |
| wr_strobe | output | 1 | One-cycle write strobe |

## Verification
The embedded assertions check on every cycle that SDA drive changes only with SCL low and that the idle state never pulls SDA. They also check that each STOP lands in a released idle, that read requests are single pulses, that write lengths stay within one to four, and that the filter output moves only after a settled input. Only the bench scenarios can show byte order, byte count per width code, pointer persistence and the fifth-byte NACK. The same holds for write commit on STOP or repeated START, address mismatch handling, mid-byte aborts and glitch rejection. The bench shows these by running a behavioural master against a modelled register file and comparing SDA drive in every SCL-high clock.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } tgt_state_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_PTR_HI,
    RL_PTR_LO,
    RL_WDATA
  } byte_role_e;

  // width code to byte count: 0 -> 1, 1 -> 2, 2/3 -> 4
  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_to_bytes = 3'd1;
      2'd1:    size_to_bytes = 3'd2;
      default: size_to_bytes = 3'd4;
    endcase
  endfunction

  // left-align the significant bytes so the MSB leaves first
  function automatic logic [31:0] align_word(input logic [31:0] w, input logic [1:0] code);
    case (code)
      2'd0:    align_word = {w[7:0], 24'h0};
      2'd1:    align_word = {w[15:0], 16'h0};
      default: align_word = w;
    endcase
  endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
`timescale 1ns/1ps
module i2c_glitch_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end
  assign raw = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_LEN < 2) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_o <= 1'b1;
        else        line_o <= raw;
      end
    end else begin : g_filt
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          line_o <= 1'b1;
          cnt    <= '0;
        end else if (raw == line_o) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_LEN - 1)) begin
          line_o <= raw;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> ($past(raw, 1) == line_o && $past(raw, 2) == line_o)); // R10
    end
  endgenerate
endmodule

// File: rtl/i2c_bus_events.sv
`timescale 1ns/1ps
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise  =  scl_f & ~scl_q;
    scl_fall  = ~scl_f &  scl_q;
    start_evt =  scl_f &  scl_q &  sda_q & ~sda_f;
    stop_evt  =  scl_f &  scl_q & ~sda_q &  sda_f;
  end
endmodule

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b0111000,
  parameter int unsigned PTR_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] rd_addr,
  output logic             rd_req,
  input  logic [31:0]      rd_data,
  input  logic [1:0]       rd_size,
  output logic [PTR_W-1:0] wr_addr,
  output logic [31:0]      wr_data,
  output logic [2:0]       wr_bytes,
  output logic             wr_strobe
);
  localparam int unsigned HI_W      = PTR_W - 8;
  localparam int unsigned MAX_WBYTE = 4;

  // line conditioning, one filter per bus line
  logic [1:0] lines_in, lines_f;
  logic       scl_f, sda_f;
  assign lines_in = {scl_i, sda_i};

  for (genvar li = 0; li < 2; li++) begin : g_line
    i2c_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(lines_in[li]), .line_o(lines_f[li]));
  end
  assign scl_f = lines_f[1];
  assign sda_f = lines_f[0];

  logic scl_rise, scl_fall, start_evt, stop_evt;
  i2c_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  // transfer state
  tgt_state_e       state;
  byte_role_e       role;
  logic [2:0]       bitcnt;
  logic [7:0]       rx_sh;
  logic [7:0]       byte_in;
  logic             byte_done, ack_pend, is_read, mack, rd_wait;
  logic [7:0]       ptr_hi;
  logic [PTR_W-1:0] ptr;
  logic [31:0]      txbuf;
  logic [2:0]       tx_left;
  logic [31:0]      wacc;
  logic [2:0]       wcnt;

  assign byte_in = {rx_sh[6:0], sda_f};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      role      <= RL_ADDR;
      bitcnt    <= '0;
      rx_sh     <= '0;
      byte_done <= 1'b0;
      ack_pend  <= 1'b0;
      is_read   <= 1'b0;
      mack      <= 1'b0;
      rd_wait   <= 1'b0;
      ptr_hi    <= '0;
      ptr       <= '0;
      txbuf     <= '0;
      tx_left   <= '0;
      wacc      <= '0;
      wcnt      <= '0;
      sda_oe    <= 1'b0;
      rd_addr   <= '0;
      rd_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_bytes  <= '0;
      wr_strobe <= 1'b0;
    end else begin
      rd_req    <= 1'b0;
      wr_strobe <= 1'b0;
      rd_wait   <= rd_req;

      if (rd_wait) begin
        txbuf   <= align_word(rd_data, rd_size);
        tx_left <= size_to_bytes(rd_size);
      end

      if (start_evt || stop_evt) begin
        if (wcnt != 3'd0) begin
          wr_strobe <= 1'b1;
          wr_addr   <= ptr;
          wr_data   <= wacc;
          wr_bytes  <= wcnt;
        end
        wcnt      <= '0;
        wacc      <= '0;
        sda_oe    <= 1'b0;
        bitcnt    <= '0;
        byte_done <= 1'b0;
        role      <= RL_ADDR;
        state     <= start_evt ? ST_RX : ST_IDLE;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh  <= byte_in;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                byte_done <= 1'b1;
                case (role)
                  RL_ADDR: begin
                    if (byte_in[7:1] == DEV_ADDR) begin
                      ack_pend <= 1'b1;
                      is_read  <= byte_in[0];
                      if (byte_in[0]) begin
                        rd_req  <= 1'b1;
                        rd_addr <= ptr;
                      end
                    end else begin
                      ack_pend <= 1'b0;
                    end
                  end
                  RL_PTR_HI: begin
                    ptr_hi   <= byte_in;
                    ack_pend <= 1'b1;
                  end
                  RL_PTR_LO: begin
                    ptr      <= {ptr_hi[HI_W-1:0], byte_in};
                    ack_pend <= 1'b1;
                  end
                  default: begin
                    if (wcnt < 3'(MAX_WBYTE)) begin
                      wacc     <= {wacc[23:0], byte_in};
                      wcnt     <= wcnt + 3'd1;
                      ack_pend <= 1'b1;
                    end else begin
                      ack_pend <= 1'b0;
                    end
                  end
                endcase
              end
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              if (ack_pend) begin
                state  <= ST_ACK_OUT;
                sda_oe <= 1'b1;
              end else begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end
            end
          end

          ST_ACK_OUT: begin
            if (scl_fall) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              state  <= ST_RX;
              case (role)
                RL_ADDR: begin
                  if (is_read) begin
                    state  <= ST_TX;
                    sda_oe <= ~txbuf[31];
                  end else begin
                    role <= RL_PTR_HI;
                  end
                end
                RL_PTR_HI: role <= RL_PTR_LO;
                RL_PTR_LO: role <= RL_WDATA;
                default:   role <= RL_WDATA;
              endcase
            end
          end

          ST_TX: begin
            if (scl_fall) begin
              txbuf  <= {txbuf[30:0], 1'b0};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                state   <= ST_ACK_IN;
                sda_oe  <= 1'b0;
                tx_left <= tx_left - 3'd1;
              end else begin
                sda_oe <= ~txbuf[30];
              end
            end
          end

          ST_ACK_IN: begin
            if (scl_rise) begin
              mack <= ~sda_f;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack && tx_left != 3'd0) begin
                state  <= ST_TX;
                sda_oe <= ~txbuf[31];
              end else begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end
            end
          end

          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f); // R8
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R3
  AST_WR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_bytes != 3'd0 && wr_bytes <= 3'd4)); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R1
endmodule

// File: tb/i2c_reg_target_test.sv
`timescale 1ns/1ps
module i2c_reg_target_test;
  localparam int HP = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_scl, m_sda;
  logic        sda_bus;
  logic        sda_oe;
  logic [15:0] rd_addr, wr_addr;
  logic        rd_req, wr_strobe;
  logic [31:0] rd_data, wr_data;
  logic [1:0]  rd_size;
  logic [2:0]  wr_bytes;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_reg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .rd_req(rd_req), .rd_data(rd_data), .rd_size(rd_size),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_bytes(wr_bytes), .wr_strobe(wr_strobe));

  // register-file model: value and width code derived from the address
  function automatic logic [31:0] rf_val(input logic [15:0] a);
    return {~a, a ^ 16'h5A5A};
  endfunction

  int          rd_seen = 0;
  int          wr_seen = 0;
  logic [15:0] last_rd_addr = '0;
  logic [15:0] last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;
  logic [2:0]  last_wr_bytes = '0;

  always @(posedge clk) begin
    if (rd_req) begin
      rd_data      <= rf_val(rd_addr);
      rd_size      <= rd_addr[1:0];
      rd_seen      <= rd_seen + 1;
      last_rd_addr <= rd_addr;
    end
    if (wr_strobe) begin
      wr_seen       <= wr_seen + 1;
      last_wr_addr  <= wr_addr;
      last_wr_data  <= wr_data;
      last_wr_bytes <= wr_bytes;
    end
  end

  // per-clock comparison of SDA drive against the model's expectation
  logic chk_on = 0, exp_oe = 0, slot_bad = 0, got_oe = 0;
  always begin
    @(negedge clk);
    #5;
    if (chk_on && m_scl && sda_oe !== exp_oe) begin
      slot_bad = 1;
      got_oe   = sda_oe;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic bit_slot(input logic val, input logic exp, input string tag, input bit glitch);
    tick(HP/2);
    m_sda = val;
    if (glitch) begin
      tick(3); m_scl = 1; tick(2); m_scl = 0; tick(HP/2 - 5);
    end else begin
      tick(HP/2);
    end
    exp_oe = exp; slot_bad = 0; chk_on = 1;
    m_scl = 1;
    tick(HP);
    m_scl = 0;
    chk_on = 0;
    checks++;
    if (slot_bad) begin
      errors++;
      $display("FAIL %s sda_oe got %0b exp %0b", tag, got_oe, exp);
    end
  endtask

  task automatic do_start();
    if (!m_scl) begin
      tick(HP/2); m_sda = 1; tick(HP/2); m_scl = 1;
    end
    tick(HP/2); m_sda = 0; tick(HP/2); m_scl = 0;
  endtask

  task automatic do_stop();
    tick(HP/2); m_sda = 0; tick(HP/2); m_scl = 1; tick(HP/2); m_sda = 1; tick(HP/2);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack, input string tag, input int gbit = -1);
    for (int i = 7; i >= 0; i--) bit_slot(b[i], 1'b0, tag, i == gbit);
    bit_slot(1'b1, ack, tag, 0);
  endtask

  task automatic recv_byte(input logic [7:0] e, input logic master_ack, input string tag);
    for (int i = 7; i >= 0; i--) bit_slot(1'b1, ~e[i], tag, 0);
    bit_slot(~master_ack, 1'b0, tag, 0);
  endtask

  // expected read bytes from the width rule, queued then drained
  task automatic read_bytes(input logic [15:0] a, input string tag);
    logic [7:0] q[$];
    logic [31:0] v = rf_val(a);
    int n = (a[1:0] == 2'd0) ? 1 : (a[1:0] == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) q.push_back(8'(v >> (8 * (n - 1 - k))));
    while (q.size() > 0) begin
      logic [7:0] b = q.pop_front();
      recv_byte(b, q.size() > 0, tag);
    end
  endtask

  task automatic ptr_read(input logic [15:0] a, input string tag);
    do_start();
    send_byte(8'h70, 1, "R1 write address ack");
    send_byte(a[15:8], 1, "R2 pointer high ack");
    send_byte(a[7:0], 1, "R2 pointer low ack");
    do_start();
    send_byte(8'h71, 1, "R1 read address ack");
    read_bytes(a, tag);
    do_stop();
    chk("R3 rd_addr equals pointer", {16'h0, last_rd_addr}, {16'h0, a});
  endtask

  initial begin
    int rd0, wr0;
    m_scl = 1; m_sda = 1; rst_n = 0;
    tick(5);
    rst_n = 1;
    tick(4);
    chk("R9 reset sda_oe", {31'h0, sda_oe}, 0);
    chk("R9 reset rd_req", {31'h0, rd_req}, 0);
    chk("R9 reset wr_strobe", {31'h0, wr_strobe}, 0);

    // read with the reset pointer
    do_start();
    send_byte(8'h71, 1, "R1 read address ack");
    read_bytes(16'h0000, "R4 one-byte read");
    do_stop();
    chk("R9 pointer resets to zero", {16'h0, last_rd_addr}, 0);
    chk("R3 single read request", rd_seen, 1);

    ptr_read(16'h1235, "R4 two-byte read");
    chk("R6 no write strobe without data", wr_seen, 0);
    ptr_read(16'hA5C6, "R4 four-byte read code 2");
    ptr_read(16'hA5C7, "R4 four-byte read code 3");

    // pointer persists into a bare read
    do_start();
    send_byte(8'h71, 1, "R3 read address ack");
    read_bytes(16'hA5C7, "R3 persistent pointer read");
    do_stop();
    chk("R3 pointer persists", {16'h0, last_rd_addr}, 32'hA5C7);

    // foreign addresses are ignored
    rd0 = rd_seen;
    do_start();
    send_byte(8'h72, 0, "R1 foreign write address nack");
    send_byte(8'h12, 0, "R1 ignored byte released");
    send_byte(8'h34, 0, "R1 ignored byte released");
    do_stop();
    do_start();
    send_byte(8'h73, 0, "R1 foreign read address nack");
    do_stop();
    chk("R1 no request for foreign address", rd_seen, rd0);
    do_start();
    send_byte(8'h71, 1, "R1 read address ack");
    read_bytes(16'hA5C7, "R1 pointer untouched read");
    do_stop();
    chk("R1 pointer untouched", {16'h0, last_rd_addr}, 32'hA5C7);

    // three-byte write
    do_start();
    send_byte(8'h70, 1, "R6 write address ack");
    send_byte(8'h04, 1, "R2 pointer high ack");
    send_byte(8'h00, 1, "R2 pointer low ack");
    send_byte(8'hDE, 1, "R6 data ack");
    send_byte(8'hAD, 1, "R6 data ack");
    send_byte(8'hBE, 1, "R6 data ack");
    do_stop();
    tick(8);
    chk("R6 one write strobe", wr_seen, 1);
    chk("R6 write address", {16'h0, last_wr_addr}, 32'h0400);
    chk("R6 write data", last_wr_data, 32'h00DEADBE);
    chk("R6 write count", {29'h0, last_wr_bytes}, 3);

    // five data bytes: fifth refused
    do_start();
    send_byte(8'h70, 1, "R6 write address ack");
    send_byte(8'h08, 1, "R2 pointer high ack");
    send_byte(8'h20, 1, "R2 pointer low ack");
    send_byte(8'h11, 1, "R6 data ack");
    send_byte(8'h22, 1, "R6 data ack");
    send_byte(8'h33, 1, "R6 data ack");
    send_byte(8'h44, 1, "R6 data ack");
    send_byte(8'h55, 0, "R6 fifth byte nack");
    do_stop();
    tick(8);
    chk("R6 strobe count after long write", wr_seen, 2);
    chk("R6 four-byte data", last_wr_data, 32'h11223344);
    chk("R6 four-byte count", {29'h0, last_wr_bytes}, 4);

    // master acknowledges the final byte
    do_start();
    send_byte(8'h70, 1, "R5 write address ack");
    send_byte(8'h00, 1, "R5 pointer high ack");
    send_byte(8'h10, 1, "R5 pointer low ack");
    do_start();
    send_byte(8'h71, 1, "R5 read address ack");
    recv_byte(rf_val(16'h0010) >> 0, 1, "R5 final byte acked by master");
    recv_byte(8'hFF, 0, "R5 released after final byte");
    do_stop();

    // STOP inside a pointer byte
    wr0 = wr_seen;
    do_start();
    send_byte(8'h70, 1, "R7 write address ack");
    for (int i = 0; i < 4; i++) bit_slot(1'b1, 1'b0, "R7 partial byte", 0);
    do_stop();
    do_start();
    send_byte(8'h71, 1, "R7 read address ack");
    read_bytes(16'h0010, "R7 read after aborted byte");
    do_stop();
    chk("R7 pointer kept after STOP abort", {16'h0, last_rd_addr}, 32'h0010);
    chk("R7 no write from aborted transfer", wr_seen, wr0);

    // repeated START inside a data byte commits earlier bytes
    do_start();
    send_byte(8'h70, 1, "R7 write address ack");
    send_byte(8'h02, 1, "R2 pointer high ack");
    send_byte(8'h00, 1, "R2 pointer low ack");
    send_byte(8'hAB, 1, "R6 data ack");
    for (int i = 0; i < 3; i++) bit_slot(1'b0, 1'b0, "R7 partial data", 0);
    do_start();
    send_byte(8'h71, 1, "R7 read address ack");
    read_bytes(16'h0200, "R7 read after repeated START");
    do_stop();
    chk("R7 commit on repeated START", wr_seen, wr0 + 1);
    chk("R7 committed data", last_wr_data, 32'h000000AB);
    chk("R7 committed address", {16'h0, last_wr_addr}, 32'h0200);

    // short SCL pulses inside pointer bytes
    do_start();
    send_byte(8'h70, 1, "R10 write address ack");
    send_byte(8'h3C, 1, "R10 glitched pointer high", 4);
    send_byte(8'h5A, 1, "R10 glitched pointer low", 2);
    do_start();
    send_byte(8'h71, 1, "R10 read address ack");
    read_bytes(16'h3C5A, "R10 read after glitches");
    do_stop();
    chk("R10 pointer unaffected by glitch", {16'h0, last_rd_addr}, 32'h3C5A);

    tick(10);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired R1 got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule